// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits between several processor request ports and one shared word memory and supplies nonblocking atomic updates. A processor issues a load-reserved to read a word. The monitor then remembers, for that processor only, a valid bit and the word address. A later store-conditional from the same processor writes the memory only if that reservation is still valid and names the same address. The processor gets back a one-bit status that tells it whether to retry its read-modify-write sequence.

Reservations are lost in three cases. The holder issues any store-conditional. Another processor completes a successful store-conditional to the same address. Any processor does a plain store to that address. A fixed-priority arbiter picks one request per cycle, so memory operations are strictly serialized. The response comes back one cycle after the grant.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads 0, and no processor holds a reservation.
- R2: Each cycle at most one request is granted. The grant goes to the lowest-indexed processor with `req_valid_i` set. A processor with no request is never granted.
- R3: A granted request produces `rsp_valid_o` set only for that processor, in the cycle right after the grant.
- R4: A load-reserved (op code 0) returns the memory word at the request address, reports status 1, and records a valid reservation on that address for the issuer.
- R5: A store-conditional (op code 1) whose issuer holds a valid reservation on the same address writes the data, reports status 1, and returns the old word.
- R6: A store-conditional without a matching valid reservation leaves memory unchanged and reports status 0. Only a store-conditional can report status 0.
- R7: Every store-conditional clears the issuer's own reservation, whatever its outcome.
- R8: A successful store-conditional clears the reservations of all other processors on the same address. Reservations on other addresses are kept.
- R9: A plain store (op codes 2 and 3) always writes, reports status 1, and clears every reservation on its address, the issuer's included.
- R10: A new load-reserved replaces the issuer's earlier reservation, so only the newest address stays reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_CORES | Request pending, one bit per processor. Held until granted |
| req_op_i | input | 2*NUM_CORES | Op code per processor: 0 load-reserved, 1 store-conditional, 2 or 3 plain store |
| req_addr_i | input | ADDR_W*NUM_CORES | Word address per processor |
| req_wdata_i | input | DATA_W*NUM_CORES | Store data per processor |
| grant_o | output | NUM_CORES | One-hot grant for the request accepted this cycle |
| rsp_valid_o | output | NUM_CORES | Response valid, one bit per processor |
| rsp_rdata_o | output | DATA_W | Memory word at the address before the operation |
| rsp_ok_o | output | 1 | Status: 1 success, 0 store-conditional failed |

## Verification
Directed sequences each target one way a reservation can be lost:
- a second conditional store after a first, which separates self-clearing from address matching;
- two processors reserving one word, which separates the winner from the loser;
- reservations on neighbouring addresses, which shows that invalidation is limited to one word;
- a plain store landing between a reservation and its conditional store;
- a reservation that is moved to a new address.

A burst where all processors request at once exposes any error in arbitration order. Seeded random rounds then mix all op codes over four addresses with random request masks. This makes address collisions and cross-invalidation frequent, and the bench model predicts every status and returned word.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LR     = 2'd0,
    OP_SC     = 2'd1,
    OP_ST     = 2'd2,
    OP_ST_ALT = 2'd3
  } lrsc_op_e;
endpackage

// File: rtl/lrsc_arbiter.sv
module lrsc_arbiter #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] req_i,
  output logic [NUM_CORES-1:0] gnt_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lrsc_resv_table.sv
module lrsc_resv_table #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] gnt_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [1:0]           op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  output logic                 own_hit_o,
  output logic [NUM_CORES-1:0] vld_o
);
  import lrsc_pkg::*;

  logic [ADDR_W-1:0] addr_q [NUM_CORES];
  logic              is_lr, is_sc;

  assign is_lr = (op_i == OP_LR);
  assign is_sc = (op_i == OP_SC);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_resv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[c]  <= 1'b0;
        addr_q[c] <= '0;
      end else if (gnt_i[c] && is_lr) begin
        vld_o[c]  <= 1'b1;
        addr_q[c] <= addr_i;
      end else if (gnt_i[c] && is_sc) begin
        vld_o[c]  <= 1'b0;
      end else if (wr_en_i && vld_o[c] && addr_q[c] == addr_i) begin
        // snoop: any completed write kills matching reservations
        vld_o[c]  <= 1'b0;
      end
    end
  end

  assign own_hit_o = vld_o[idx_i] && (addr_q[idx_i] == addr_i);
endmodule

// File: rtl/lrsc_word_mem.sv
module lrsc_word_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[w] <= '0;
      else if (we_i && addr_i == ADDR_W'(w))   mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES-1:0]          req_valid_i,
  input  logic [2*NUM_CORES-1:0]        req_op_i,
  input  logic [ADDR_W*NUM_CORES-1:0]   req_addr_i,
  input  logic [DATA_W*NUM_CORES-1:0]   req_wdata_i,
  output logic [NUM_CORES-1:0]          grant_o,
  output logic [NUM_CORES-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_rdata_o,
  output logic                          rsp_ok_o
);
  import lrsc_pkg::*;

  logic [1:0]        op_a   [NUM_CORES];
  logic [ADDR_W-1:0] addr_a [NUM_CORES];
  logic [DATA_W-1:0] data_a [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_unpack
    assign op_a[c]   = req_op_i[2*c +: 2];
    assign addr_a[c] = req_addr_i[ADDR_W*c +: ADDR_W];
    assign data_a[c] = req_wdata_i[DATA_W*c +: DATA_W];
  end

  logic [IDX_W-1:0]     sel_idx;
  logic [1:0]           sel_op;
  logic [ADDR_W-1:0]    sel_addr;
  logic [DATA_W-1:0]    sel_data;
  logic                 any_gnt, own_hit, mem_we, is_sc, is_st;
  logic [NUM_CORES-1:0] resv_vld;
  logic [DATA_W-1:0]    mem_rdata;

  lrsc_arbiter #(.NUM_CORES(NUM_CORES)) i_arb (
    .req_i (req_valid_i),
    .gnt_o (grant_o),
    .idx_o (sel_idx)
  );

  assign sel_op   = op_a[sel_idx];
  assign sel_addr = addr_a[sel_idx];
  assign sel_data = data_a[sel_idx];
  assign any_gnt  = |grant_o;
  assign is_sc    = (sel_op == OP_SC);
  assign is_st    = sel_op[1];
  assign mem_we   = any_gnt && (is_st || (is_sc && own_hit));

  lrsc_resv_table #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) i_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_i     (grant_o),
    .idx_i     (sel_idx),
    .op_i      (sel_op),
    .addr_i    (sel_addr),
    .wr_en_i   (mem_we),
    .own_hit_o (own_hit),
    .vld_o     (resv_vld)
  );

  lrsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (sel_addr),
    .wdata_i (sel_data),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_rdata_o <= '0;
      rsp_ok_o    <= 1'b0;
    end else begin
      rsp_valid_o <= grant_o;
      if (any_gnt) begin
        rsp_rdata_o <= mem_rdata;
        rsp_ok_o    <= !(is_sc && !own_hit);
      end
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CORES-1:0] req_valid_i,
  input logic [NUM_CORES-1:0] grant_o,
  input logic [NUM_CORES-1:0] rsp_valid_o,
  input logic                 rsp_ok_o,
  input logic [1:0]           gnt_op_i,
  input logic [NUM_CORES-1:0] resv_vld_i
);
  import lrsc_pkg::*;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_onehot_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_valid_i) == '0);
  assert_low_index_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i & (grant_o - 1'b1)) == '0);
  assert_rsp_after_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> rsp_valid_o == $past(grant_o));
  assert_fail_only_sc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (|rsp_valid_o) && !rsp_ok_o) |-> $past(gnt_op_i) == OP_SC);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assert_lr_reserves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[c] && gnt_op_i == OP_LR) |=> resv_vld_i[c]);
    assert_sc_drops_own_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[c] && gnt_op_i == OP_SC) |=> !resv_vld_i[c]);
  end
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NUM_CORES(NUM_CORES)) i_lrsc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .grant_o     (grant_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o),
  .gnt_op_i    (sel_op),
  .resv_vld_i  (resv_vld)
);

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]  grant, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_ok;

  always #5 clk = ~clk;

  lrsc_monitor #(.NUM_CORES(N), .ADDR_W(AW), .DATA_W(DW)) i_lrsc_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .grant_o(grant),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_ok_o(rsp_ok)
  );

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] mem_m [1<<AW];
  logic          rv [N];
  logic [AW-1:0] ra [N];
  logic [1:0]    t_op [N];
  logic [AW-1:0] t_addr [N];
  logic [DW-1:0] t_data [N];

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_apply(input int c, output logic [DW-1:0] er, output logic eo);
    logic [AW-1:0] a;
    logic hit;
    a  = t_addr[c];
    er = mem_m[a];
    eo = 1'b1;
    if (t_op[c] == 2'd0) begin
      rv[c] = 1'b1; ra[c] = a;
    end else if (t_op[c] == 2'd1) begin
      hit = rv[c] && ra[c] == a;
      rv[c] = 1'b0;
      eo = hit;
      if (hit) begin
        mem_m[a] = t_data[c];
        for (int k = 0; k < N; k++) if (rv[k] && ra[k] == a) rv[k] = 1'b0;
      end
    end else begin
      mem_m[a] = t_data[c];
      for (int k = 0; k < N; k++) if (rv[k] && ra[k] == a) rv[k] = 1'b0;
    end
  endtask

  task automatic drive_fields();
    for (int k = 0; k < N; k++) begin
      req_op[2*k +: 2]     = t_op[k];
      req_addr[AW*k +: AW] = t_addr[k];
      req_wdata[DW*k +: DW] = t_data[k];
    end
  endtask

  // called at a negedge; serves all cores in mask, checking each step
  task automatic run_batch(input logic [N-1:0] mask, input string tag);
    logic [N-1:0]  pend;
    int            c;
    logic [DW-1:0] er;
    logic          eo;
    string         t;
    pend = mask;
    drive_fields();
    while (pend != '0) begin
      req_valid = pend;
      #1;
      c = 0;
      for (int k = N-1; k >= 0; k--) if (pend[k]) c = k;
      check(grant == N'(1 << c), "R2 grant", grant, N'(1 << c));
      model_apply(c, er, eo);
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid == N'(1 << c), "R3 rsp_valid", rsp_valid, N'(1 << c));
      if (tag != "") t = tag;
      else if (t_op[c] == 2'd0) t = "R4";
      else if (t_op[c] == 2'd1) t = eo ? "R5" : "R6";
      else t = "R9";
      check(rsp_rdata == er, {t, " rdata"}, rsp_rdata, er);
      check(rsp_ok == eo, {t, " status"}, rsp_ok, eo);
      pend[c] = 1'b0;
    end
    req_valid = '0;
  endtask

  task automatic one(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    t_op[c] = op; t_addr[c] = a; t_data[c] = d;
    run_batch(N'(1 << c), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < (1 << AW); k++) mem_m[k] = '0;
    for (int k = 0; k < N; k++) begin
      rv[k] = 1'b0; ra[k] = '0; t_op[k] = '0; t_addr[k] = '0; t_data[k] = '0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(rsp_valid == '0, "R1 rsp during reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == '0 && grant == '0, "R1 idle after reset", {grant, rsp_valid}, 0);

    one(1, 2'd1, 4'd3, 16'hAAAA, "R1");   // SC after reset fails
    one(2, 2'd0, 4'd9, 16'h0, "R1");      // memory reads zero
    one(0, 2'd0, 4'd3, 16'h0, "R1");      // failed SC left word 0

    one(0, 2'd1, 4'd3, 16'h1234, "R5");
    one(0, 2'd1, 4'd3, 16'h5555, "R7");   // reservation consumed
    one(1, 2'd0, 4'd3, 16'h0, "R6");      // still 1234

    one(0, 2'd0, 4'd4, 16'h0, "R8");
    one(1, 2'd0, 4'd4, 16'h0, "R8");
    one(2, 2'd0, 4'd5, 16'h0, "R8");
    one(1, 2'd1, 4'd4, 16'h00B1, "R8");
    one(0, 2'd1, 4'd4, 16'h00B0, "R8");   // lost to core 1
    one(2, 2'd1, 4'd5, 16'h00C2, "R8");   // other address kept

    one(3, 2'd0, 4'd7, 16'h0, "R9");
    one(0, 2'd3, 4'd7, 16'h7777, "R9");
    one(3, 2'd1, 4'd7, 16'h0F0F, "R9");
    one(2, 2'd0, 4'd8, 16'h0, "R9");
    one(2, 2'd2, 4'd8, 16'h8888, "R9");   // own store also clears
    one(2, 2'd1, 4'd8, 16'h0, "R9");

    one(1, 2'd0, 4'd2, 16'h0, "R10");
    one(1, 2'd0, 4'd6, 16'h0, "R10");
    one(1, 2'd1, 4'd2, 16'h2222, "R10");
    one(1, 2'd0, 4'd2, 16'h0, "R10");
    one(1, 2'd0, 4'd6, 16'h0, "R10");
    one(1, 2'd1, 4'd6, 16'h6666, "R10");

    for (int k = 0; k < N; k++) begin
      t_op[k] = 2'd0; t_addr[k] = AW'(k); t_data[k] = '0;
    end
    run_batch('1, "");                     // R2 all request at once

    for (int r = 0; r < 300; r++) begin
      for (int k = 0; k < N; k++) begin
        t_op[k]   = 2'($urandom_range(0, 3));
        t_addr[k] = AW'($urandom_range(0, 3));
        t_data[k] = DW'($urandom);
      end
      run_batch(N'($urandom_range(1, (1 << N) - 1)), "");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule